// File: doc/BRIEF.md
# Load/Store Conflict Ordering Matrix

This block keeps memory operations in a safe order across a small set of load/store units. Whenever a unit is given a new memory operation, the block records, in a square matrix of single-bit cells, which of the operations already in flight the new one has to wait for. A cell in row *i*, column *j* means "unit *i* waits for unit *j*". From these cells it drives, for every unit, a hold on reading memory (for a load) or a hold on writing memory (for a store). These holds are meant as extra blocking inputs to the function-unit dependency matrix that schedules the rest of the pipeline.

The conflict test is deliberately coarse. Only a short upper slice of each address is stored and compared, so every comparator is only a few bits wide. Two operations whose upper slices differ can never touch the same location, and they are left independent. Two operations whose slices match are treated as conflicting, whatever their lower address bits say. A store waits for every older load and every older store in its region. A load waits for every older store in its region. Loads never wait for loads.

When a unit reports completion, its whole row and its whole column are cleared on the next clock edge. A unit whose row is left empty by this sees its hold drop in the following cycle.

Top module: `lsq_ord_matrix`

## Requirements
- R1: After a synchronous active-low reset, every read hold and write hold is low, and no unit is tracked.
- R2: A load issued while an older store from the same upper-address region is outstanding has its read hold asserted from the cycle after issue.
- R3: A store issued while an older load from the same upper-address region is outstanding has its write hold asserted from the cycle after issue.
- R4: A store issued while an older store from the same upper-address region is outstanding has its write hold asserted from the cycle after issue.
- R5: A load never waits for another load, whatever their addresses.
- R6: Operations whose compared upper address bits (the top TAG_W bits, default addr[31:24]) differ never block each other.
- R7: Operations with equal upper bits block each other according to R2 to R4 even when their lower address bits differ.
- R8: A completion pulse for unit j clears every cell in row j and column j at the next edge. A unit left with no cells set drops its hold in the cycle after that edge. Several units may complete in the same cycle.
- R9: A unit holding a load may assert only its read hold, and a unit holding a store may assert only its write hold. An idle unit asserts neither.
- R10: An operation issued in the same cycle as an older operation completes does not wait for that completing operation.
- R11: A new issue never adds cells to the rows of units that were already in flight, so older operations are never made to wait for younger ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | A new memory operation is issued this cycle |
| issue_unit | input | IDX_W (2) | Index of the load/store unit that receives the operation |
| issue_is_store | input | 1 | 1 for a store, 0 for a load |
| issue_addr | input | ADDR_W (32) | Memory address of the operation; only the top TAG_W bits are used |
| done | input | NUM_UNITS (4) | One bit per unit; a bit pulses when that unit's operation completes |
| rd_hold | output | NUM_UNITS (4) | Per-unit hold on the memory read of a load |
| wr_hold | output | NUM_UNITS (4) | Per-unit hold on the memory write of a store |

## Verification
The assertions take for granted that an issue always targets a unit that is idle, and that this unit does not also report completion in the same cycle. Under that precondition they check that no unit ever waits for itself, that cells appear only between operations whose region tags match and where at least one is a store, and that older rows never gain cells. The stimulus keeps within the precondition by drawing the issue target only from units that the bench's own model holds idle, and by drawing completions only from units it holds busy. Region tags are drawn from a set of three values so that matching and differing tags both occur often.

// File: rtl/lsq_ord_pkg.sv
// Package: shared types and the coarse conflict rule for the ordering matrix.
// Assumes: the caller supplies the result of the region-tag compare.
package lsq_ord_pkg;

    // Kind of memory operation held by a load/store unit.
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } mem_op_e;

    // Two ops in the same region conflict unless both are loads.
    function automatic logic ops_conflict(input mem_op_e newer,
                                          input mem_op_e older,
                                          input logic    same_region);
        return same_region && ((newer == OP_STORE) || (older == OP_STORE));
    endfunction

endpackage

// File: rtl/lsq_ord_slot.sv
// Module: one tracking slot per load/store unit. It holds busy, kind and
// region tag, and tells the matrix whether an op issued this cycle must
// wait for the op held here.
// Assumes: an issue never targets a busy slot, and a slot that is
// retiring is not issued in the same cycle.
module lsq_ord_slot
    import lsq_ord_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int IDX_W = 2,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [IDX_W-1:0] issue_unit,
    input  mem_op_e          issue_op,
    input  logic [TAG_W-1:0] issue_tag,
    input  logic             retire,
    output logic             busy,
    output mem_op_e          op,
    output logic [TAG_W-1:0] tag,
    output logic             must_wait
);

    logic take;
    logic same_region;

    assign take        = issue_valid && (issue_unit == IDX_W'(IDX));
    assign same_region = (tag == issue_tag);

    // Occupancy, kind and region of the op held by this unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            op   <= OP_LOAD;
            tag  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            op   <= issue_op;
            tag  <= issue_tag;
        end else if (retire) begin
            busy <= 1'b0;
        end
    end

    // Flag a hazard for a different unit's new op, unless this op is leaving.
    always_comb begin
        must_wait = busy && !retire && !take &&
                    ops_conflict(issue_op, op, same_region);
    end

    // Input precondition: the target of an issue is idle.
    AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !busy); // R11

    // A slot retired without a new issue is idle afterwards.
    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !take) |=> !busy); // R8

endmodule

// File: rtl/lsq_ord_row.sv
// Module: one row of blocking cells. Cell j set means the op in this row's
// unit waits for the op in unit j.
// Assumes: the row is loaded only when its own unit is issued; the loaded
// pattern already excludes this unit and any unit that is retiring.
module lsq_ord_row #(
    parameter int NUM_UNITS = 4,
    parameter int IDX       = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_UNITS-1:0] new_cells,
    input  logic [NUM_UNITS-1:0] retire,
    output logic [NUM_UNITS-1:0] cells
);

    // Load on issue, else clear retiring columns, and wipe on own retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (load) begin
            cells <= new_cells & ~retire;
        end else if (retire[IDX]) begin
            cells <= '0;
        end else begin
            cells <= cells & ~retire;
        end
    end

    // A unit never waits for itself.
    AST_NO_SELF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cells[IDX]); // R11

    // Without a reload, the row only loses cells.
    AST_ROW_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ((cells & ~$past(cells)) == '0)); // R11

    // A retiring unit's column is clear after the edge.
    generate
        for (genvar j = 0; j < NUM_UNITS; j++) begin : g_col_clear
            AST_COL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
                retire[j] |=> !cells[j]); // R8
        end
    endgenerate

endmodule

// File: rtl/lsq_ord_matrix.sv
// Module: load/store conflict ordering matrix (top). On issue it compares the
// upper address slice of the new op against every op in flight and records
// the ones it must wait for; it drives per-unit read/write holds and clears
// rows and columns on completion.
// Assumes: NUM_UNITS >= 2; an issue targets an idle unit that is not
// completing in the same cycle; completion pulses for idle units are harmless.
module lsq_ord_matrix
    import lsq_ord_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int ADDR_W    = 32,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    input  logic [IDX_W-1:0]     issue_unit,
    input  logic                 issue_is_store,
    input  logic [ADDR_W-1:0]    issue_addr,
    input  logic [NUM_UNITS-1:0] done,
    output logic [NUM_UNITS-1:0] rd_hold,
    output logic [NUM_UNITS-1:0] wr_hold
);

    logic [TAG_W-1:0]     issue_tag;
    mem_op_e              issue_op;
    logic [NUM_UNITS-1:0] slot_busy;
    logic [NUM_UNITS-1:0] hazard;
    logic [NUM_UNITS-1:0] cells [NUM_UNITS];
    mem_op_e              slot_op  [NUM_UNITS];
    logic [TAG_W-1:0]     slot_tag [NUM_UNITS];

    // Reduce the address to its region tag and the flag to an op kind.
    always_comb begin
        issue_tag = issue_addr[ADDR_W-1 -: TAG_W];
        issue_op  = issue_is_store ? OP_STORE : OP_LOAD;
    end

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            logic row_load;

            lsq_ord_slot #(
                .TAG_W (TAG_W),
                .IDX_W (IDX_W),
                .IDX   (u)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .issue_valid (issue_valid),
                .issue_unit  (issue_unit),
                .issue_op    (issue_op),
                .issue_tag   (issue_tag),
                .retire      (done[u]),
                .busy        (slot_busy[u]),
                .op          (slot_op[u]),
                .tag         (slot_tag[u]),
                .must_wait   (hazard[u])
            );

            assign row_load = issue_valid && (issue_unit == IDX_W'(u));

            lsq_ord_row #(
                .NUM_UNITS (NUM_UNITS),
                .IDX       (u)
            ) u_row (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (row_load),
                .new_cells (hazard),
                .retire    (done),
                .cells     (cells[u])
            );

            // Drive the hold that matches the kind of op this unit holds.
            always_comb begin
                rd_hold[u] = slot_busy[u] && (slot_op[u] == OP_LOAD)  && (|cells[u]);
                wr_hold[u] = slot_busy[u] && (slot_op[u] == OP_STORE) && (|cells[u]);
            end

            // An idle unit carries no cells.
            AST_IDLE_ROW_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                !slot_busy[u] |-> (cells[u] == '0)); // R8

            for (genvar j = 0; j < NUM_UNITS; j++) begin : g_pair
                // Cells only link ops of one region, never load to load.
                AST_CELL_SAME_REGION: assert property (@(posedge clk) disable iff (!rst_n)
                    cells[u][j] |-> (slot_tag[u] == slot_tag[j])); // R6
                AST_CELL_NOT_TWO_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
                    cells[u][j] |-> (slot_op[u] == OP_STORE || slot_op[j] == OP_STORE)); // R5
                AST_CELL_TARGET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                    cells[u][j] |-> slot_busy[j]); // R10
            end
        end
    endgenerate

    // Input precondition: the issued unit is not completing in that cycle.
    AST_NO_ISSUE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !done[issue_unit]); // R10

    // Per unit, at most one kind of hold is raised.
    AST_HOLD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold & wr_hold) == '0); // R9

endmodule

// File: tb/lsq_ord_matrix_tb.sv
module lsq_ord_matrix_tb;
    localparam int N      = 4;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 8;
    localparam int IDX_W  = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_valid = 1'b0;
    logic [IDX_W-1:0]  issue_unit = '0;
    logic              issue_is_store = 1'b0;
    logic [ADDR_W-1:0] issue_addr = '0;
    logic [N-1:0]      done = '0;
    logic [N-1:0]      rd_hold;
    logic [N-1:0]      wr_hold;

    int tests = 0;
    int fails = 0;

    // Reference model state, built from the requirements.
    bit           m_busy [N];
    bit           m_st   [N];
    bit [TAG_W-1:0] m_tag [N];
    bit [N-1:0]   m_blk  [N];

    always #10 clk = ~clk; // 50 MHz

    lsq_ord_matrix #(.NUM_UNITS(N), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_unit(issue_unit),
        .issue_is_store(issue_is_store), .issue_addr(issue_addr), .done(done),
        .rd_hold(rd_hold), .wr_hold(wr_hold)
    );

    function automatic bit [N-1:0] exp_rd();
        bit [N-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i] = m_busy[i] && !m_st[i] && (m_blk[i] != '0);
        return r;
    endfunction

    function automatic bit [N-1:0] exp_wr();
        bit [N-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i] = m_busy[i] && m_st[i] && (m_blk[i] != '0);
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_st[i] = 0; m_tag[i] = '0; m_blk[i] = '0;
        end
    endtask

    // Advance the model by one edge with the given inputs.
    task automatic model_step(bit iv, int iu, bit ist, bit [ADDR_W-1:0] ia, bit [N-1:0] dn);
        bit [N-1:0] row = '0;
        bit [TAG_W-1:0] t = ia[ADDR_W-1 -: TAG_W];
        if (iv) begin
            for (int j = 0; j < N; j++)
                row[j] = (j != iu) && m_busy[j] && !dn[j] && (m_tag[j] == t) && (ist || m_st[j]);
        end
        for (int j = 0; j < N; j++) begin
            if (dn[j]) begin
                m_busy[j] = 0;
                m_blk[j]  = '0;
                for (int k = 0; k < N; k++) m_blk[k][j] = 1'b0;
            end
        end
        if (iv) begin
            m_busy[iu] = 1; m_st[iu] = ist; m_tag[iu] = t; m_blk[iu] = row;
        end
    endtask

    task automatic check(string req);
        bit [N-1:0] er = exp_rd();
        bit [N-1:0] ew = exp_wr();
        tests++;
        if (rd_hold !== er || wr_hold !== ew) begin
            fails++;
            $display("FAIL %s: rd_hold=%b wr_hold=%b expected rd_hold=%b wr_hold=%b",
                     req, rd_hold, wr_hold, er, ew);
        end
    endtask

    // Check a single hold bit against a fixed expectation.
    task automatic check_bit(string req, bit actual, bit expected);
        tests++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, actual, expected);
        end
    endtask

    // One cycle: drive at negedge, model on edge, leave at next negedge.
    task automatic cycle(bit iv, int iu, bit ist, bit [ADDR_W-1:0] ia, bit [N-1:0] dn);
        issue_valid = iv; issue_unit = IDX_W'(iu); issue_is_store = ist;
        issue_addr = ia; done = dn;
        @(posedge clk);
        model_step(iv, iu, ist, ia, dn);
        @(negedge clk);
        issue_valid = 0; done = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5eed_1234);
        model_reset();
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");
        check_bit("R1 no hold after reset", |(rd_hold | wr_hold), 1'b0);

        // R2 + R7: store then load, same region, different low bits.
        cycle(1, 0, 1, 32'h1200_0000, '0);
        check("R2 older store idle");
        cycle(1, 1, 0, 32'h1234_5678, '0);
        check_bit("R2 load waits on store", rd_hold[1], 1'b1);
        check_bit("R7 low bits ignored", rd_hold[1], 1'b1);
        check_bit("R11 older store not held", wr_hold[0], 1'b0);
        // R8: completion releases.
        cycle(0, 0, 0, '0, 4'b0001);
        check_bit("R8 load released", rd_hold[1], 1'b0);
        // R3: store after load.
        cycle(1, 2, 1, 32'h12ff_0000, '0);
        check_bit("R3 store waits on load", wr_hold[2], 1'b1);
        check_bit("R9 store raises no read hold", rd_hold[2], 1'b0);
        // R2 again: new load waits on store 2 but not on load 1 (R5).
        cycle(1, 0, 0, 32'h1200_0004, '0);
        check("R2 load behind store and load");
        // R4: store behind store; also R8 with multiple completions.
        cycle(0, 0, 0, '0, 4'b0011);
        cycle(1, 3, 1, 32'h1280_0000, '0);
        check_bit("R4 store waits on store", wr_hold[3], 1'b1);
        cycle(0, 0, 0, '0, 4'b1100);
        check("R8 all idle");
        // R5: loads only.
        cycle(1, 0, 0, 32'h1200_0000, '0);
        cycle(1, 1, 0, 32'h1200_0000, '0);
        check_bit("R5 load never waits on load", rd_hold[1], 1'b0);
        // R6: different region store.
        cycle(1, 2, 1, 32'h3400_0000, '0);
        check_bit("R6 other region free", wr_hold[2], 1'b0);
        // R10: store issued while loads 0 and 1 complete.
        cycle(1, 3, 1, 32'h1200_0000, 4'b0011);
        check_bit("R10 no wait on completing op", wr_hold[3], 1'b0);
        cycle(0, 0, 0, '0, 4'b1100);
        check("R1 idle again");

        // Constrained random phase.
        for (int c = 0; c < 400; c++) begin
            bit [N-1:0] dn = '0;
            bit iv = 0;
            int iu = 0;
            int idle_cnt = 0;
            bit [TAG_W-1:0] tg;
            bit [ADDR_W-1:0] ia;
            for (int j = 0; j < N; j++)
                if (m_busy[j] && ($urandom_range(0, 3) == 0)) dn[j] = 1'b1;
            for (int j = 0; j < N; j++) if (!m_busy[j]) idle_cnt++;
            if (idle_cnt > 0 && $urandom_range(0, 1) == 1) begin
                int pick = $urandom_range(0, idle_cnt - 1);
                for (int j = 0; j < N; j++) begin
                    if (!m_busy[j]) begin
                        if (pick == 0) begin iu = j; iv = 1; end
                        pick--;
                    end
                end
            end
            case ($urandom_range(0, 2))
                0: tg = 8'h12;
                1: tg = 8'h34;
                default: tg = 8'h56;
            endcase
            ia = {tg, 24'($urandom)};
            cycle(iv, iu, 1'($urandom_range(0, 1)), ia, dn);
            check("R9 random holds match R2 R3 R4 R5 R6 R8 R10");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule